// File: doc/BRIEF.md
# Flash Status and Write-Protect Unit

This block keeps the eight-bit status byte of a serial NOR flash and rules on every command that would change the array or the status byte. An SPI front end decodes each command and hands over one strobe with an operation code, the 24-bit target address and, for a status write, its data byte. One cycle later the unit acknowledges the command and says whether it was accepted. When the command needs a self-timed cycle, the unit also pulses a start line to the operation timer. The timer answers with a done pulse when that cycle ends.

The status byte holds a one-time lock bit (bit 7), a three-bit protect code (bits 4:2), the write-enable latch (bit 1) and the busy flag (bit 0). Bits 6 and 5 always read 0. The protect code marks part of an eight-block array as read-only, counted from the top block down. Bits 18:16 of the address select the block. The unit keeps a non-volatile copy of the lock and protect fields and a live (volatile) copy. Status reads always return the live copy. A volatile-write prefix lets the next status write update the live copy at once, without a timed cycle.

Top module: `fsr_guard`

## Requirements
- R1: After reset the status byte is 00h and cmd_ack is 0.
- R2: Op 1 (set write enable) sets status bit 1. Op 2 (clear write enable) clears it. Both are always accepted.
- R3: Op 4 (status write), op 5 (page program), op 6 (sector erase), op 7 (block erase) and op 8 (chip erase) are rejected when bit 1 is 0. A rejected command does not change the status byte, except that a status write still uses up a pending volatile prefix (see R11).
- R4: cmd_ack follows a strobe by one cycle, with cmd_ok showing the verdict. An accepted timed command pulses tmr_start in that same cycle and puts its op code on tmr_op. Status bit 0 is 1 from that cycle until the cycle after a tmr_done pulse. At that point bits 0 and 1 both fall to 0.
- R5: While bit 0 is 1, ops 4 to 8 are rejected. This includes a status write that follows a volatile prefix.
- R6: A timed status write leaves the status byte unchanged while busy. When the cycle ends, data bits 7 and 4:2 are loaded. Status bits 6 and 5 stay 0, whatever the data byte holds.
- R7: The protect code maps to protected blocks, taken from address bits 18:16, as follows: 0 protects none, 1 protects block 7, 2 protects blocks 6–7, 3 protects blocks 4–7, and 4 to 7 protect every block. Ops 5, 6 and 7 aimed at a protected block are rejected.
- R8: Op 8 is rejected whenever the protect code is not zero.
- R9: While bit 7 is 1, every status write is rejected, including one after a volatile prefix. Bits 7 and 4:2 then never change.
- R10: Op 3 (volatile prefix) is accepted and does not touch bit 1. If the next command is op 4, that write is accepted without bit 1 being set. It starts no timed cycle, leaves bit 1 as it was, and loads data bits 7 and 4:2 into the status byte, visible in the cycle of its acknowledge.
- R11: Any other command, including op 0 (any other command), that falls between op 3 and op 4 cancels the prefix. A rejected status write also uses up the prefix.
- R12: A tmr_done pulse while bit 0 is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 4 | Operation code: 0 other, 1 set write enable, 2 clear write enable, 3 volatile prefix, 4 status write, 5 page program, 6 sector erase, 7 block erase, 8 chip erase |
| cmd_addr | input | ADDR_W | Target address of the command |
| cmd_data | input | 8 | Data byte of a status write |
| tmr_done | input | 1 | End of the self-timed cycle |
| status | output | 8 | Live status byte |
| cmd_ack | output | 1 | Verdict valid, one cycle after the strobe |
| cmd_ok | output | 1 | Command accepted |
| tmr_start | output | 1 | Start pulse to the operation timer |
| tmr_op | output | 4 | Op code of the last started timed command |

## Verification
The bench targets the points where the gating rules touch each other. These are the protect-code edges between blocks 3 and 4 and between blocks 5 and 6, where an off-by-one comparison would accept an erase in a protected block or refuse a legal one. A volatile prefix that a different command interrupts must not open the next status write, or a stale prefix would let a write through without the write enable. A prefixed status write during a busy cycle must be refused, or the protect field would change under a running erase. A stray done pulse while idle must not clear the write enable. A lock that latches must freeze the protect field even against volatile writes.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int BP_W   = 3;
    localparam int STAT_W = 8;

    typedef enum logic [3:0] {
        OP_OTHER  = 4'd0,
        OP_WEN    = 4'd1,
        OP_WDIS   = 4'd2,
        OP_VPFX   = 4'd3,
        OP_SWRITE = 4'd4,
        OP_PROG   = 4'd5,
        OP_SERASE = 4'd6,
        OP_BERASE = 4'd7,
        OP_CERASE = 4'd8
    } op_e;

    // Lock and protect field, held twice: non-volatile and live copies.
    typedef struct packed {
        logic            lock;
        logic [BP_W-1:0] bp;
    } prot_t;

    // Verdict of one command strobe.
    typedef struct packed {
        logic ok;
        logic start;
        logic nv_write;
        logic vol_write;
    } verdict_t;

    function automatic logic is_array_op(op_e op);
        return (op == OP_PROG) || (op == OP_SERASE) || (op == OP_BERASE);
    endfunction

    function automatic prot_t field_of(logic [STAT_W-1:0] d);
        prot_t p;
        p.lock = d[7];
        p.bp   = d[4:2];
        return p;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(prot_t p, logic wel, logic wip);
        return {p.lock, 2'b00, p.bp, wel, wip};
    endfunction

    // Block b of 2**blk_w blocks is covered by protect code c.
    function automatic logic blk_covered(int b, int blk_w, logic [BP_W-1:0] c);
        int nblk;
        nblk = 1 << blk_w;
        if (c == '0)
            return 1'b0;
        else if (int'(c) > blk_w)
            return 1'b1;
        else
            return b >= (nblk - (1 << (int'(c) - 1)));
    endfunction

endpackage

// File: rtl/fsr_protect.sv
module fsr_protect
    import fsr_pkg::*;
#(
    parameter int BLK_W = 3
) (
    input  logic [BP_W-1:0]  bp_i,
    input  logic [BLK_W-1:0] blk_i,
    output logic             hit_o,
    output logic             any_o
);

    localparam int NBLK = 1 << BLK_W;

    logic [NBLK-1:0] mask;

    generate
        for (genvar b = 0; b < NBLK; b++) begin : g_blk
            assign mask[b] = blk_covered(b, BLK_W, bp_i);
        end
    endgenerate

    assign hit_o = mask[blk_i];
    assign any_o = |bp_i;

endmodule

// File: rtl/fsr_cmd_eval.sv
module fsr_cmd_eval
    import fsr_pkg::*;
(
    input  logic     valid_i,
    input  op_e      op_i,
    input  logic     wel_i,
    input  logic     wip_i,
    input  logic     lock_i,
    input  logic     vpend_i,
    input  logic     hit_i,
    input  logic     any_i,
    output verdict_t verdict_o
);

    always_comb begin
        verdict_o = '0;
        if (valid_i) begin
            case (op_i)
                OP_SWRITE: begin
                    if (!wip_i && !lock_i) begin
                        if (vpend_i) begin
                            verdict_o.ok        = 1'b1;
                            verdict_o.vol_write = 1'b1;
                        end else if (wel_i) begin
                            verdict_o.ok       = 1'b1;
                            verdict_o.start    = 1'b1;
                            verdict_o.nv_write = 1'b1;
                        end
                    end
                end
                OP_PROG, OP_SERASE, OP_BERASE: begin
                    if (!wip_i && wel_i && !hit_i) begin
                        verdict_o.ok    = 1'b1;
                        verdict_o.start = 1'b1;
                    end
                end
                OP_CERASE: begin
                    if (!wip_i && wel_i && !any_i) begin
                        verdict_o.ok    = 1'b1;
                        verdict_o.start = 1'b1;
                    end
                end
                default: verdict_o.ok = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/fsr_status_store.sv
module fsr_status_store
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  op_e               op_i,
    input  logic [STAT_W-1:0] data_i,
    input  verdict_t          verdict_i,
    input  logic              done_i,
    output prot_t             prot_o,
    output logic              lock_o,
    output logic              wel_o,
    output logic              wip_o,
    output logic              vpend_o
);

    prot_t nv_q;
    prot_t live_q;
    prot_t pend_q;
    logic  pend_nv_q;
    logic  wel_q;
    logic  wip_q;
    logic  vpend_q;

    logic  unused_data_bits;
    assign unused_data_bits = ^{data_i[6:5], data_i[1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            nv_q      <= '0;
            live_q    <= '0;
            pend_q    <= '0;
            pend_nv_q <= 1'b0;
            wel_q     <= 1'b0;
            wip_q     <= 1'b0;
            vpend_q   <= 1'b0;
        end else begin
            if (done_i && wip_q) begin
                wip_q     <= 1'b0;
                wel_q     <= 1'b0;
                pend_nv_q <= 1'b0;
                if (pend_nv_q) begin
                    nv_q   <= pend_q;
                    live_q <= pend_q;
                end
            end
            if (valid_i) begin
                vpend_q <= (op_i == OP_VPFX);
                if (op_i == OP_WEN)
                    wel_q <= 1'b1;
                else if (op_i == OP_WDIS)
                    wel_q <= 1'b0;
                if (verdict_i.start) begin
                    wip_q     <= 1'b1;
                    pend_nv_q <= verdict_i.nv_write;
                    pend_q    <= field_of(data_i);
                end
                if (verdict_i.vol_write)
                    live_q <= field_of(data_i);
            end
        end
    end

    assign prot_o  = live_q;
    assign lock_o  = live_q.lock | nv_q.lock;
    assign wel_o   = wel_q;
    assign wip_o   = wip_q;
    assign vpend_o = vpend_q;

endmodule

// File: rtl/fsr_guard.sv
module fsr_guard
    import fsr_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int BLK_LSB = 16,
    parameter int BLK_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              tmr_done,
    output logic [7:0]        status,
    output logic              cmd_ack,
    output logic              cmd_ok,
    output logic              tmr_start,
    output logic [3:0]        tmr_op
);

    localparam int BLK_MSB = BLK_LSB + BLK_W - 1;

    op_e              op;
    logic [BLK_W-1:0] blk;
    logic             unused_addr_bits;
    prot_t            prot;
    logic             lock, wel, wip, vpend, hit, any_bp;
    verdict_t         verdict;

    assign op  = op_e'(cmd_op);
    assign blk = cmd_addr[BLK_MSB:BLK_LSB];

    generate
        if (BLK_MSB < ADDR_W - 1) begin : g_hi
            assign unused_addr_bits = ^{cmd_addr[ADDR_W-1:BLK_MSB+1], cmd_addr[BLK_LSB-1:0]};
        end else begin : g_nohi
            assign unused_addr_bits = ^cmd_addr[BLK_LSB-1:0];
        end
    endgenerate

    fsr_protect #(.BLK_W(BLK_W)) prot_i (
        .bp_i  (prot.bp),
        .blk_i (blk),
        .hit_o (hit),
        .any_o (any_bp)
    );

    fsr_cmd_eval eval_i (
        .valid_i   (cmd_valid),
        .op_i      (op),
        .wel_i     (wel),
        .wip_i     (wip),
        .lock_i    (lock),
        .vpend_i   (vpend),
        .hit_i     (hit),
        .any_i     (any_bp),
        .verdict_o (verdict)
    );

    fsr_status_store store_i (
        .clk       (clk),
        .rst       (rst),
        .valid_i   (cmd_valid),
        .op_i      (op),
        .data_i    (cmd_data),
        .verdict_i (verdict),
        .done_i    (tmr_done),
        .prot_o    (prot),
        .lock_o    (lock),
        .wel_o     (wel),
        .wip_o     (wip),
        .vpend_o   (vpend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_ack   <= 1'b0;
            cmd_ok    <= 1'b0;
            tmr_start <= 1'b0;
            tmr_op    <= '0;
        end else begin
            cmd_ack   <= cmd_valid;
            cmd_ok    <= verdict.ok;
            tmr_start <= verdict.start;
            if (verdict.start)
                tmr_op <= cmd_op;
        end
    end

    assign status = pack_status(prot, wel, wip);

endmodule

// File: rtl/fsr_guard_chk.sv
module fsr_guard_chk
    import fsr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [3:0] cmd_op,
    input logic       tmr_done,
    input logic [7:0] status,
    input logic       cmd_ack,
    input logic       cmd_ok,
    input logic       tmr_start
);

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        tmr_start |-> status[0]); // R4

    AST_START_IS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        tmr_start |-> (cmd_ack && cmd_ok)); // R4

    AST_BUSY_BLOCKS_MODIFY: assert property (@(posedge clk) disable iff (rst)
        (cmd_ack && cmd_ok && ($past(cmd_op) >= 4'd4) && ($past(cmd_op) <= 4'd8))
        |-> !$past(status[0])); // R5

    AST_WEL_GATES_ARRAY: assert property (@(posedge clk) disable iff (rst)
        (cmd_ack && cmd_ok && ($past(cmd_op) >= 4'd5) && ($past(cmd_op) <= 4'd8))
        |-> $past(status[1])); // R3

    AST_CHIP_ERASE_OPEN: assert property (@(posedge clk) disable iff (rst)
        (cmd_ack && cmd_ok && ($past(cmd_op) == 4'd8)) |-> ($past(status[4:2]) == 3'd0)); // R8

    AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (rst)
        status[7] |=> (status[7:2] == $past(status[7:2]))); // R9

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        status[6:5] == 2'b00); // R6

    AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (tmr_done && !status[0] && !cmd_valid) |=> (status == $past(status))); // R12

endmodule

bind fsr_guard fsr_guard_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .tmr_done  (tmr_done),
    .status    (status),
    .cmd_ack   (cmd_ack),
    .cmd_ok    (cmd_ok),
    .tmr_start (tmr_start)
);

// File: tb/fsr_guard_tb_top.sv
module fsr_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [23:0] cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic        tmr_done = 1'b0;
    logic [7:0]  status;
    logic        cmd_ack, cmd_ok, tmr_start;
    logic [3:0]  tmr_op;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_run = 0;

    always #2 clk = ~clk;

    fsr_guard dut_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .tmr_done  (tmr_done),
        .status    (status),
        .cmd_ack   (cmd_ack),
        .cmd_ok    (cmd_ok),
        .tmr_start (tmr_start),
        .tmr_op    (tmr_op)
    );

    typedef struct packed {
        logic        is_done;
        logic [3:0]  op;
        logic [23:0] addr;
        logic [7:0]  data;
        logic        exp_ok;
        logic        exp_start;
        logic [7:0]  exp_stat;
        logic [7:0]  req;
    } vec_t;

    function automatic vec_t mk(logic d, logic [3:0] op, logic [23:0] a, logic [7:0] dat,
                                logic ok, logic st, logic [7:0] s, logic [7:0] r);
        vec_t v;
        v.is_done = d; v.op = op; v.addr = a; v.data = dat;
        v.exp_ok = ok; v.exp_start = st; v.exp_stat = s; v.req = r;
        return v;
    endfunction

    localparam int NV = 46;
    localparam vec_t VEC [NV] = '{
        mk(0, 4, 24'h000000, 8'hFF, 0, 0, 8'h00, 3),  // R3 status write without enable
        mk(0, 5, 24'h000000, 8'h00, 0, 0, 8'h00, 3),  // R3
        mk(0, 8, 24'h000000, 8'h00, 0, 0, 8'h00, 3),  // R3
        mk(0, 1, 24'h000000, 8'h00, 1, 0, 8'h02, 2),  // R2 set enable
        mk(0, 2, 24'h000000, 8'h00, 1, 0, 8'h00, 2),  // R2 clear enable
        mk(0, 1, 24'h000000, 8'h00, 1, 0, 8'h02, 2),  // R2
        mk(0, 5, 24'h010000, 8'h00, 1, 1, 8'h03, 4),  // R4 program starts
        mk(0, 6, 24'h000000, 8'h00, 0, 0, 8'h03, 5),  // R5 busy blocks erase
        mk(1, 0, 24'h000000, 8'h00, 0, 0, 8'h00, 4),  // R4 done clears busy+enable
        mk(1, 0, 24'h000000, 8'h00, 0, 0, 8'h00, 12), // R12 idle done
        mk(0, 1, 24'h000000, 8'h00, 1, 0, 8'h02, 2),
        mk(0, 4, 24'h000000, 8'h6B, 1, 1, 8'h03, 6),  // R6 unchanged while busy
        mk(1, 0, 24'h000000, 8'h00, 0, 0, 8'h08, 6),  // R6 code 2 loaded, 6/5 zero
        mk(0, 1, 24'h000000, 8'h00, 1, 0, 8'h0A, 2),
        mk(0, 5, 24'h060000, 8'h00, 0, 0, 8'h0A, 7),  // R7 block 6 protected
        mk(0, 6, 24'h07F000, 8'h00, 0, 0, 8'h0A, 7),  // R7 block 7 protected
        mk(0, 7, 24'h05FFFF, 8'h00, 1, 1, 8'h0B, 7),  // R7 block 5 open
        mk(1, 0, 24'h000000, 8'h00, 0, 0, 8'h08, 4),
        mk(0, 1, 24'h000000, 8'h00, 1, 0, 8'h0A, 2),
        mk(0, 8, 24'h000000, 8'h00, 0, 0, 8'h0A, 8),  // R8 chip erase refused
        mk(0, 3, 24'h000000, 8'h00, 1, 0, 8'h0A, 10), // R10 prefix keeps enable
        mk(0, 4, 24'h000000, 8'h0C, 1, 0, 8'h0E, 10), // R10 immediate, no start
        mk(0, 5, 24'h040000, 8'h00, 0, 0, 8'h0E, 7),  // R7 code 3 block 4
        mk(0, 5, 24'h03FFFF, 8'h00, 1, 1, 8'h0F, 7),  // R7 code 3 block 3 open
        mk(1, 0, 24'h000000, 8'h00, 0, 0, 8'h0C, 4),
        mk(0, 3, 24'h000000, 8'h00, 1, 0, 8'h0C, 11),
        mk(0, 2, 24'h000000, 8'h00, 1, 0, 8'h0C, 11), // R11 interloper
        mk(0, 4, 24'h000000, 8'h00, 0, 0, 8'h0C, 11), // R11 prefix cancelled
        mk(0, 3, 24'h000000, 8'h00, 1, 0, 8'h0C, 11),
        mk(0, 0, 24'h000000, 8'h00, 1, 0, 8'h0C, 11), // R11 other command
        mk(0, 4, 24'h000000, 8'h00, 0, 0, 8'h0C, 11), // R11
        mk(0, 3, 24'h000000, 8'h00, 1, 0, 8'h0C, 10),
        mk(0, 4, 24'h000000, 8'h00, 1, 0, 8'h00, 10), // R10 without enable
        mk(0, 1, 24'h000000, 8'h00, 1, 0, 8'h02, 2),
        mk(0, 8, 24'h000000, 8'h00, 1, 1, 8'h03, 8),  // R8 open chip erase
        mk(0, 3, 24'h000000, 8'h00, 1, 0, 8'h03, 5),
        mk(0, 4, 24'h000000, 8'h00, 0, 0, 8'h03, 5),  // R5 prefixed write while busy
        mk(1, 0, 24'h000000, 8'h00, 0, 0, 8'h00, 4),
        mk(0, 1, 24'h000000, 8'h00, 1, 0, 8'h02, 2),
        mk(0, 4, 24'h000000, 8'h90, 1, 1, 8'h03, 9),  // R9 set lock, code 4
        mk(1, 0, 24'h000000, 8'h00, 0, 0, 8'h90, 9),  // R9
        mk(0, 1, 24'h000000, 8'h00, 1, 0, 8'h92, 2),
        mk(0, 4, 24'h000000, 8'h00, 0, 0, 8'h92, 9),  // R9 locked
        mk(0, 3, 24'h000000, 8'h00, 1, 0, 8'h92, 9),
        mk(0, 4, 24'h000000, 8'h00, 0, 0, 8'h92, 9),  // R9 locked volatile
        mk(0, 5, 24'h000000, 8'h00, 0, 0, 8'h92, 7)   // R7 code 4 protects all
    };

    task automatic check(int req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send(logic [3:0] op, logic [23:0] a, logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        tmr_done = 1'b1;
        @(negedge clk);
        tmr_done = 1'b0;
    endtask

    task automatic wrap_up();
        if (!done_run) begin
            done_run = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        wrap_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(1, "reset status", status, 8'h00);   // R1
        check(1, "reset ack", cmd_ack, 1'b0);      // R1

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_done) begin
                pulse_done();
                check(VEC[i].req, "no ack on done", cmd_ack, 1'b0);
            end else begin
                send(VEC[i].op, VEC[i].addr, VEC[i].data);
                check(VEC[i].req, "ack", cmd_ack, 1'b1);
                check(VEC[i].req, "ok", cmd_ok, VEC[i].exp_ok);
                check(VEC[i].req, "start", tmr_start, VEC[i].exp_start);
                if (VEC[i].exp_start)
                    check(VEC[i].req, "tmr_op", tmr_op, VEC[i].op);
            end
            check(VEC[i].req, "status", status, VEC[i].exp_stat);
        end

        // R1: reset in mid-run clears a locked status byte
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(1, "reset after lock", status, 8'h00);

        // R4: busy holds until done, whatever the wait
        send(4'd1, 24'h0, 8'h0);
        send(4'd6, 24'h000123, 8'h0);
        check(4, "erase start", tmr_start, 1'b1);
        check(4, "erase op", tmr_op, 4'd6);
        repeat (6) @(negedge clk);
        check(4, "busy held", status, 8'h03);
        check(4, "start is a pulse", tmr_start, 1'b0);
        pulse_done();
        check(4, "after done", status, 8'h00);

        wrap_up();
    end

endmodule